// File: doc/BRIEF.md
# Integer ALU with status flags

This block is the integer arithmetic stage of an execution unit. It takes an operation code, an operand size, two operands and the current six-bit status flag vector. It returns the result and an updated flag vector. It handles plain add and subtract, their carry-chained forms, increment, decrement and negate. It works on byte, half-word or word operands, and the size decides which bit counts as the most significant one.

The flags follow the usual two's-complement conventions. Subtraction adds the inverted second operand, and carry reports a borrow. Overflow is the carry into the top bit XOR the carry out of it. Auxiliary carry covers the boundary between bit 3 and bit 4. Parity looks only at the low byte. Each operation comes with a per-flag update mask. Any flag not in the mask passes from the incoming vector to the output unchanged, so increment and decrement keep the carry. The mask is also an output, so a register file can use it as a set of write enables. By default the outputs are registered, one cycle after the inputs. A parameter can make the block purely combinational instead.

Top module: `flag_alu`

## Requirements
- R1: Operation code (op_i): 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 increment, 5 decrement, 6 negate (zero minus opa_i). The result is the arithmetic value truncated to the selected size.
- R2: Size code (size_i): 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits, and 3 is treated as 32 bits. Result bits above the selected size are always zero, whatever the operand bits above the size hold.
- R3: Carry (flag bit 0) is the unsigned carry out of the top bit for add, add with carry and increment. It is the unsigned borrow for subtract, subtract with borrow, decrement and negate. So negate sets carry exactly when the sized operand is nonzero.
- R4: Overflow (flag bit 1) is set exactly when the signed result at the selected size lies outside the signed range of that size.
- R5: Sign (flag bit 2) equals the top bit of the sized result. Zero (flag bit 3) is set exactly when the sized result is all zeros.
- R6: Auxiliary carry (flag bit 4) is set on a carry out of bit 3 into bit 4 for the adding operations, and on a borrow out of the low nibble for the subtracting operations.
- R7: Parity (flag bit 5) is set when bits 7..0 of the result hold an even number of ones.
- R8: Add with carry adds flags_i bit 0 to the sum. Subtract with borrow also subtracts it. Both carry and borrow chain across words.
- R9: Increment and decrement present update mask 6'b111110, and flags_o bit 0 equals flags_i bit 0.
- R10: Operation code 7 is a no-operation: the result is zero, the update mask is zero and flags_o equals flags_i.
- R11: Operations 0 to 3 and 6 present update mask 6'b111111. For every flag whose mask bit is clear, flags_o carries the flags_i bit in the same position.
- R12: With OUT_REG=1, the outputs show the inputs' result on the clock edge after they are applied. While rst_n is low, result_o, flags_o and flag_upd_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| size_i | input | SZ_W (2) | Operand size code |
| opa_i | input | DATA_W (32) | First operand |
| opb_i | input | DATA_W (32) | Second operand |
| flags_i | input | 6 | Current flags; bit 0 is the incoming carry |
| result_o | output | DATA_W (32) | Result, zero above the selected size |
| flags_o | output | 6 | Updated flag vector |
| flag_upd_o | output | 6 | Per-flag update mask of the operation |

## Verification
The bench builds the block with N_SIZES=3, which gives 8, 16 and 32-bit lanes, and with OUT_REG=1. These settings reach every size code, including the reserved code that falls back to the widest lane, and the one-cycle latency of the output register. A 32-bit word is narrow enough for the bench model to compute the exact unsigned and signed sums in 64-bit integers, so carry and overflow are checked against true range limits rather than bit formulas. The same widths let random upper operand bits test the zeroing above the byte and half-word sizes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_INC = 3'd4,
        OP_DEC = 3'd5,
        OP_NEG = 3'd6,
        OP_NOP = 3'd7
    } alu_op_e;

    localparam int FLG_W  = 6;
    localparam int FLG_CY = 0;
    localparam int FLG_OV = 1;
    localparam int FLG_SG = 2;
    localparam int FLG_ZR = 3;
    localparam int FLG_AX = 4;
    localparam int FLG_PE = 5;

    localparam logic [FLG_W-1:0] UPD_ALL   = 6'b111111;
    localparam logic [FLG_W-1:0] UPD_NO_CY = 6'b111110;

endpackage

// File: rtl/alu_opnd_prep.sv
module alu_opnd_prep
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] x_o,
    output logic [DATA_W-1:0] y_o,
    output logic              cin_o,
    output logic              brw_o,
    output logic [FLG_W-1:0]  upd_o,
    output logic              nop_o
);

    always_comb begin
        x_o   = opa_i;
        y_o   = opb_i;
        cin_o = 1'b0;
        brw_o = 1'b0;
        upd_o = UPD_ALL;
        nop_o = 1'b0;
        unique case (op_i)
            OP_ADD: ;
            OP_ADC: cin_o = cy_i;
            OP_SUB: begin
                y_o   = ~opb_i;
                cin_o = 1'b1;
                brw_o = 1'b1;
            end
            OP_SBB: begin
                y_o   = ~opb_i;
                cin_o = ~cy_i;
                brw_o = 1'b1;
            end
            OP_INC: begin
                y_o   = '0;
                cin_o = 1'b1;
                upd_o = UPD_NO_CY;
            end
            OP_DEC: begin
                y_o   = '1;
                brw_o = 1'b1;
                upd_o = UPD_NO_CY;
            end
            OP_NEG: begin
                x_o   = '0;
                y_o   = ~opa_i;
                cin_o = 1'b1;
                brw_o = 1'b1;
            end
            default: begin
                upd_o = '0;
                nop_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/alu_lane_adder.sv
module alu_lane_adder #(
    parameter int W      = 8,
    parameter int DATA_W = 32
) (
    input  logic [W-1:0]      x_i,
    input  logic [W-1:0]      y_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              msb_o,
    output logic              cout_o,
    output logic              cmsb_o,
    output logic              cnib_o
);

    logic [W:0] full;

    assign full   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
    assign cout_o = full[W];
    assign msb_o  = full[W-1];
    // carry arriving at the top bit and at bit 4, recovered from the sum bits
    assign cmsb_o = x_i[W-1] ^ y_i[W-1] ^ full[W-1];
    assign cnib_o = x_i[4] ^ y_i[4] ^ full[4];

    always_comb begin
        sum_o          = '0;
        sum_o[W-1:0]   = full[W-1:0];
    end

endmodule

// File: rtl/alu_status_gen.sv
module alu_status_gen
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              msb_i,
    input  logic              cout_i,
    input  logic              cmsb_i,
    input  logic              cnib_i,
    input  logic              brw_i,
    output logic [FLG_W-1:0]  flags_o
);

    always_comb begin
        flags_o         = '0;
        flags_o[FLG_CY] = cout_i ^ brw_i;
        flags_o[FLG_OV] = cout_i ^ cmsb_i;
        flags_o[FLG_SG] = msb_i;
        flags_o[FLG_ZR] = (res_i == '0);
        flags_o[FLG_AX] = cnib_i ^ brw_i;
        flags_o[FLG_PE] = ~^res_i[7:0];
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_pkg::*;
#(
    parameter int N_SIZES = 3,
    parameter bit OUT_REG = 1'b1,
    localparam int DATA_W = 8 << (N_SIZES - 1),
    localparam int SZ_W   = (N_SIZES > 1) ? $clog2(N_SIZES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [SZ_W-1:0]   size_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [FLG_W-1:0]  flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [FLG_W-1:0]  flags_o,
    output logic [FLG_W-1:0]  flag_upd_o
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [FLG_W-1:0]  flags;
        logic [FLG_W-1:0]  upd;
    } alu_out_t;

    alu_op_e           op;
    logic [DATA_W-1:0] x, y;
    logic              cin, brw, nop;
    logic [FLG_W-1:0]  upd;

    assign op = alu_op_e'(op_i);

    alu_opnd_prep #(.DATA_W(DATA_W)) u_prep (
        .op_i  (op),
        .opa_i (opa_i),
        .opb_i (opb_i),
        .cy_i  (flags_i[FLG_CY]),
        .x_o   (x),
        .y_o   (y),
        .cin_o (cin),
        .brw_o (brw),
        .upd_o (upd),
        .nop_o (nop)
    );

    logic [DATA_W-1:0] lane_sum  [N_SIZES];
    logic              lane_msb  [N_SIZES];
    logic              lane_cout [N_SIZES];
    logic              lane_cmsb [N_SIZES];
    logic              lane_cnib [N_SIZES];

    for (genvar k = 0; k < N_SIZES; k++) begin : g_lane
        localparam int LW = 8 << k;
        alu_lane_adder #(.W(LW), .DATA_W(DATA_W)) u_lane (
            .x_i    (x[LW-1:0]),
            .y_i    (y[LW-1:0]),
            .cin_i  (cin),
            .sum_o  (lane_sum[k]),
            .msb_o  (lane_msb[k]),
            .cout_o (lane_cout[k]),
            .cmsb_o (lane_cmsb[k]),
            .cnib_o (lane_cnib[k])
        );
    end

    logic [SZ_W-1:0]   sz_idx;
    logic [DATA_W-1:0] sel_sum;
    logic              sel_msb, sel_cout, sel_cmsb, sel_cnib;
    logic [FLG_W-1:0]  new_flags;

    always_comb begin
        sz_idx   = (int'(size_i) >= N_SIZES) ? SZ_W'(N_SIZES - 1) : size_i;
        sel_sum  = lane_sum[sz_idx];
        sel_msb  = lane_msb[sz_idx];
        sel_cout = lane_cout[sz_idx];
        sel_cmsb = lane_cmsb[sz_idx];
        sel_cnib = lane_cnib[sz_idx];
    end

    alu_status_gen #(.DATA_W(DATA_W)) u_status (
        .res_i   (sel_sum),
        .msb_i   (sel_msb),
        .cout_i  (sel_cout),
        .cmsb_i  (sel_cmsb),
        .cnib_i  (sel_cnib),
        .brw_i   (brw),
        .flags_o (new_flags)
    );

    alu_out_t out_d, out_q;

    always_comb begin
        out_d.result = nop ? '0 : sel_sum;
        out_d.flags  = (new_flags & upd) | (flags_i & ~upd);
        out_d.upd    = upd;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign result_o   = out_q.result;
    assign flags_o    = out_q.flags;
    assign flag_upd_o = out_q.upd;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int DATA_W  = 32,
    parameter int SZ_W    = 2,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [SZ_W-1:0]   size_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [5:0]        flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic [5:0]        flags_o,
    input logic [5:0]        flag_upd_o
);

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_o[3] |-> (flags_o[3] == (result_o == '0)));

    // R7
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_o[5] |-> (flags_o[5] == ~^result_o[7:0]));

    if (OUT_REG) begin : g_seq
        // R9
        incdec_keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd4 || op_i == 3'd5) |=>
                (flags_o[0] == $past(flags_i[0]) && flag_upd_o == 6'b111110));

        // R10
        nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd7) |=>
                (flags_o == $past(flags_i) && result_o == '0 && flag_upd_o == '0));

        // R2
        byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (size_i == '0) |=> (result_o[DATA_W-1:8] == '0));

        // R3
        neg_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd6 && size_i == '0) |=>
                (flags_o[0] == ($past(opa_i[7:0]) != 8'h00)));
    end

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W), .SZ_W(SZ_W), .OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .size_i     (size_i),
    .opa_i      (opa_i),
    .flags_i    (flags_i),
    .result_o   (result_o),
    .flags_o    (flags_o),
    .flag_upd_o (flag_upd_o)
);

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic [5:0]  flags_i = '0;
    logic [31:0] result_o;
    logic [5:0]  flags_o, flag_upd_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flag_alu i_flag_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
        .opa_i(opa_i), .opb_i(opb_i), .flags_i(flags_i),
        .result_o(result_o), .flags_o(flags_o), .flag_upd_o(flag_upd_o)
    );

    // bench model from the requirements, exact integer arithmetic
    function automatic void model(input logic [2:0] op, input logic [1:0] sz,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic [5:0] fi, output logic [31:0] r,
                                  output logic [5:0] f, output logic [5:0] u);
        int w = (sz == 2'd3) ? 32 : (8 << sz);
        longint unsigned mk = (64'd1 << w) - 1;
        longint unsigned ux, uy, ures;
        longint sx, sy, sres, smax, smin;
        logic cc, sub, cy, nib;
        logic [5:0] nf;
        if (op == 3'd7) begin
            r = '0; u = '0; f = fi;
            return;
        end
        cc = 1'b0; sub = 1'b0; u = 6'b111111;
        ux = a & mk; uy = b & mk;
        case (op)
            3'd1: cc = fi[0];
            3'd2: sub = 1'b1;
            3'd3: begin sub = 1'b1; cc = fi[0]; end
            3'd4: begin uy = 1; u = 6'b111110; end
            3'd5: begin uy = 1; sub = 1'b1; u = 6'b111110; end
            3'd6: begin uy = a & mk; ux = 0; sub = 1'b1; end
            default: ;
        endcase
        sx = (ux >> (w - 1)) != 0 ? longint'(ux) - longint'(mk) - 1 : longint'(ux);
        sy = (uy >> (w - 1)) != 0 ? longint'(uy) - longint'(mk) - 1 : longint'(uy);
        smax = longint'(mk >> 1);
        smin = -smax - 1;
        if (!sub) begin
            ures = ux + uy + cc;
            cy   = ures > mk;
            sres = sx + sy + cc;
            nib  = ((ux & 15) + (uy & 15) + cc) > 15;
        end else begin
            ures = ux - uy - cc;
            cy   = ux < (uy + cc);
            sres = sx - sy - cc;
            nib  = (ux & 15) < ((uy & 15) + cc);
        end
        ures = ures & mk;
        r = 32'(ures);
        nf[0] = cy;
        nf[1] = (sres > smax) || (sres < smin);
        nf[2] = r[w-1];
        nf[3] = (r == 0);
        nf[4] = nib;
        nf[5] = ~^r[7:0];
        f = (nf & u) | (fi & ~u);
    endfunction

    task automatic check(input string req, input logic [31:0] er,
                         input logic [5:0] ef, input logic [5:0] eu);
        n_checks++;
        if (result_o !== er || flags_o !== ef || flag_upd_o !== eu) begin
            n_fail++;
            $display("FAIL %s: result=%h flags=%b upd=%b expected result=%h flags=%b upd=%b",
                     req, result_o, flags_o, flag_upd_o, er, ef, eu);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [5:0] fi, input string req);
        logic [31:0] er;
        logic [5:0]  ef, eu;
        @(negedge clk);
        op_i = op; size_i = sz; opa_i = a; opb_i = b; flags_i = fi;
        model(op, sz, a, b, fi, er, ef, eu);
        @(negedge clk);
        check(req, er, ef, eu);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: expected completion, got timeout");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12 reset state
        op_i = 3'd0; size_i = 2'd0; opa_i = 32'hFF; opb_i = 32'h1; flags_i = 6'h3F;
        @(negedge clk);
        check("R12 reset", 32'h0, 6'h0, 6'h0);
        rst_n = 1'b1;

        // R3 R5 R6 R7: 8-bit FF + 1, literal expectation
        @(negedge clk);
        op_i = 3'd0; size_i = 2'd0; opa_i = 32'hFF; opb_i = 32'h1; flags_i = 6'h0;
        @(negedge clk);
        check("R3 R5 R6 R7 R12 ff+1", 32'h00, 6'b111001, 6'b111111);

        // R4: 8-bit 26h - 95h, literal expectation
        @(negedge clk);
        op_i = 3'd2; opa_i = 32'h26; opb_i = 32'h95;
        @(negedge clk);
        check("R4 26-95", 32'h91, 6'b000111, 6'b111111);

        run(3'd2, 2'd0, 32'h0,  32'h1,  6'h0,  "R3 R6 sub 0-1");
        run(3'd4, 2'd0, 32'h7F, 32'h0,  6'h0,  "R4 R9 inc 7f");
        run(3'd6, 2'd0, 32'h80, 32'h0,  6'h0,  "R3 R4 neg 80");
        run(3'd6, 2'd1, 32'hFFFF0000, 32'h0, 6'h1, "R3 R11 neg zero");
        run(3'd4, 2'd0, 32'hFF, 32'h0,  6'b101011, "R9 inc keeps carry 1");
        run(3'd5, 2'd2, 32'h0,  32'h0,  6'b010100, "R9 dec keeps carry 0");
        run(3'd7, 2'd2, 32'h1234, 32'h5678, 6'b110101, "R10 nop");
        run(3'd1, 2'd1, 32'hFFFF, 32'h0, 6'h1, "R8 adc chain");
        run(3'd3, 2'd1, 32'h0, 32'h0, 6'h1, "R8 sbb chain");
        run(3'd0, 2'd1, 32'h7FFF, 32'h1, 6'h0, "R4 16-bit overflow");
        run(3'd0, 2'd3, 32'hFFFFFFFF, 32'h1, 6'h0, "R2 size 3 as 32-bit");
        run(3'd0, 2'd0, 32'hABCD12F0, 32'h55550020, 6'h0, "R2 upper bits zero");
        run(3'd1, 2'd2, 32'h7FFFFFFF, 32'h0, 6'h1, "R1 R4 R8 adc 32-bit");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            case ($urandom % 6)
                0: b = a;
                1: b = 32'h0;
                2: a = 32'hFFFFFFFF;
                default: ;
            endcase
            run(3'($urandom % 8), 2'($urandom % 4), a, b, 6'($urandom % 64),
                "R1 R2 R3 R4 R5 R6 R7 R8 R11 random");
        end

        finished = 1;
        summary();
    end

endmodule